// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words, A and B, and reports on three outputs whether A is greater than, equal to or less than B. The words are split into nibble-wide slices. Each slice resolves its own bit pairs, starting from the most significant pair. It passes its verdict up to the next more significant slice, and that slice uses the verdict only when all of its own bit pairs match. As a result the slices form a ripple chain with no glue logic between them. The whole block is combinational.

Three cascade inputs feed the least significant slice, so one instance can extend another instance of the block. A stand-alone comparator ties the equal cascade input high and the greater and less cascade inputs low. Because the ordering is purely positional, the result is correct for natural binary words and for packed BCD words alike. A parameter picks how each slice finds its decision: a bit-priority scan, or a borrow taken from a nibble-wide subtraction.

Top module: `mcmp_ripple`

## Requirements
- R1: The most significant unequal bit pair decides the result. Differences in any less significant bit, nibble or slice then have no effect on the outputs.
- R2: When A and B differ, gt_o is high exactly when A > B as unsigned numbers and lt_o is high exactly when A < B, whatever the cascade inputs are.
- R3: When A equals B and casc_eq_i is high, the outputs are eq_o=1, gt_o=0 and lt_o=0, even if casc_gt_i or casc_lt_i is high.
- R4: When A equals B and casc_eq_i is low, gt_o copies casc_gt_i, lt_o copies casc_lt_i and eq_o is 0. This includes the illegal case where both cascade inputs are high, which drives both gt_o and lt_o high.
- R5: eq_o is high only when every bit of A matches the bit of B at the same position and casc_eq_i is high.
- R6: When A and B differ, exactly one of gt_o and lt_o is high and eq_o is low.
- R7: WIDTH must be a positive multiple of NIB_W (4 by default), or elaboration stops. Slice k handles bits [NIB_W*k+NIB_W-1 : NIB_W*k], and its three outputs drive the cascade inputs of slice k+1.
- R8: Words that hold packed BCD digits (each nibble 0 to 9) compare in decimal order. For example, 0x0099 against 0x0100 gives lt_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A, unsigned or packed BCD |
| b_i | input | WIDTH | Operand B, unsigned or packed BCD |
| casc_gt_i | input | 1 | Greater verdict from a less significant stage; tie low when unused |
| casc_eq_i | input | 1 | Equal verdict from a less significant stage; tie high when unused |
| casc_lt_i | input | 1 | Less verdict from a less significant stage; tie low when unused |
| gt_o | output | 1 | A is greater than B |
| eq_o | output | 1 | A equals B and the incoming verdict is equal |
| lt_o | output | 1 | A is less than B |

## Verification
The bound checker watches every input change. It tests the whole-word ordering when the operands differ, the single-flag rule, the forcing of gt_o and lt_o low under an equal cascade, the copying of the cascade inputs otherwise, and the condition for eq_o. Some properties only the bench's chosen scenarios can show. These are that a decision in a high slice overrides contrary lower slices and hostile cascade inputs, that the illegal both-high cascade passes through intact, and that packed BCD words order decimally across digit boundaries.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;

   // Three-way verdict carried between slices
   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } mcmp_rel_t;

   // How a slice finds the first unequal bit pair
   typedef enum logic [0:0] {
      SCAN_PRIORITY = 1'b0,
      SCAN_SUBTRACT = 1'b1
   } mcmp_scan_e;

   // Merge a local decision with the verdict from below
   function automatic mcmp_rel_t mcmp_merge(input logic loc_hi,
                                            input logic loc_lo,
                                            input mcmp_rel_t below);
      mcmp_rel_t r;
      if (loc_hi) begin
         r = '{gt: 1'b1, eq: 1'b0, lt: 1'b0};
      end else if (loc_lo) begin
         r = '{gt: 1'b0, eq: 1'b0, lt: 1'b1};
      end else if (below.eq) begin
         r = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
      end else begin
         r = '{gt: below.gt, eq: 1'b0, lt: below.lt};
      end
      return r;
   endfunction

endpackage

// File: rtl/mcmp_pair_scan.sv
module mcmp_pair_scan
   import mcmp_pkg::*;
#(
   parameter int         NIB_W = 4,
   parameter mcmp_scan_e SCAN  = SCAN_PRIORITY
) (
   input  logic [NIB_W-1:0] a_nib,
   input  logic [NIB_W-1:0] b_nib,
   output logic             hi_o,
   output logic             lo_o
);

   localparam int DIFF_W = NIB_W + 1;

   generate
      if (NIB_W < 1) begin : g_bad_w
         $error("mcmp_pair_scan: NIB_W must be at least 1");
      end

      if (SCAN == SCAN_PRIORITY) begin : g_priority
         logic [NIB_W-1:0] pair_ne;
         logic             decided;

         for (genvar i = 0; i < NIB_W; i++) begin : g_pair
            assign pair_ne[i] = a_nib[i] ^ b_nib[i];
         end

         always_comb begin
            hi_o    = 1'b0;
            lo_o    = 1'b0;
            decided = 1'b0;
            for (int i = NIB_W - 1; i >= 0; i--) begin
               if (!decided && pair_ne[i]) begin
                  decided = 1'b1;
                  hi_o    = a_nib[i];
                  lo_o    = b_nib[i];
               end
            end
         end
      end else begin : g_subtract
         logic [DIFF_W-1:0] diff;
         assign diff = {1'b0, a_nib} - {1'b0, b_nib};
         assign lo_o = diff[DIFF_W-1];
         assign hi_o = ~diff[DIFF_W-1] & (|diff[NIB_W-1:0]);
      end
   endgenerate

endmodule

// File: rtl/mcmp_slice.sv
module mcmp_slice
   import mcmp_pkg::*;
#(
   parameter int         NIB_W = 4,
   parameter mcmp_scan_e SCAN  = SCAN_PRIORITY
) (
   input  logic [NIB_W-1:0] a_nib,
   input  logic [NIB_W-1:0] b_nib,
   input  mcmp_rel_t        rel_in,
   output mcmp_rel_t        rel_out
);

   logic loc_hi;
   logic loc_lo;

   mcmp_pair_scan #(
      .NIB_W (NIB_W),
      .SCAN  (SCAN)
   ) u_scan (
      .a_nib (a_nib),
      .b_nib (b_nib),
      .hi_o  (loc_hi),
      .lo_o  (loc_lo)
   );

   always_comb begin
      rel_out = mcmp_merge(loc_hi, loc_lo, rel_in);
   end

endmodule

// File: rtl/mcmp_ripple.sv
module mcmp_ripple
   import mcmp_pkg::*;
#(
   parameter int         WIDTH = 16,
   parameter int         NIB_W = 4,
   parameter mcmp_scan_e SCAN  = SCAN_PRIORITY
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             casc_gt_i,
   input  logic             casc_eq_i,
   input  logic             casc_lt_i,
   output logic             gt_o,
   output logic             eq_o,
   output logic             lt_o
);

   localparam int N_SLICE = (NIB_W > 0) ? (WIDTH / NIB_W) : 1;

   generate
      if (NIB_W < 1 || WIDTH < NIB_W || (WIDTH % NIB_W) != 0) begin : g_bad_width
         $error("mcmp_ripple: WIDTH must be a positive multiple of NIB_W");
      end
   endgenerate

   mcmp_rel_t link [N_SLICE+1];

   assign link[0] = '{gt: casc_gt_i, eq: casc_eq_i, lt: casc_lt_i};

   generate
      for (genvar k = 0; k < N_SLICE; k++) begin : g_slice
         mcmp_slice #(
            .NIB_W (NIB_W),
            .SCAN  (SCAN)
         ) u_slice (
            .a_nib   (a_i[k*NIB_W +: NIB_W]),
            .b_nib   (b_i[k*NIB_W +: NIB_W]),
            .rel_in  (link[k]),
            .rel_out (link[k+1])
         );
      end
   endgenerate

   assign gt_o = link[N_SLICE].gt;
   assign eq_o = link[N_SLICE].eq;
   assign lt_o = link[N_SLICE].lt;

endmodule

// File: rtl/mcmp_chk.sv
module mcmp_chk #(
   parameter int WIDTH = 16
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic             casc_gt_i,
   input logic             casc_eq_i,
   input logic             casc_lt_i,
   input logic             gt_o,
   input logic             eq_o,
   input logic             lt_o
);

   always_comb begin
      if (a_i != b_i) begin
         // R2
         order_gt_chk: assert (gt_o == (a_i > b_i));
         // R2
         order_lt_chk: assert (lt_o == (a_i < b_i));
         // R6
         single_flag_chk: assert (($countones({gt_o, lt_o}) == 1) && !eq_o);
      end
      if ((a_i == b_i) && casc_eq_i) begin
         // R3
         eq_forces_chk: assert (eq_o && !gt_o && !lt_o);
      end
      if ((a_i == b_i) && !casc_eq_i) begin
         // R4
         cascade_copy_chk: assert ((gt_o == casc_gt_i) && (lt_o == casc_lt_i) && !eq_o);
      end
      if (eq_o) begin
         // R5
         eq_cause_chk: assert ((a_i == b_i) && casc_eq_i);
      end
   end

endmodule

bind mcmp_ripple mcmp_chk #(.WIDTH(WIDTH)) u_mcmp_chk (
   .a_i       (a_i),
   .b_i       (b_i),
   .casc_gt_i (casc_gt_i),
   .casc_eq_i (casc_eq_i),
   .casc_lt_i (casc_lt_i),
   .gt_o      (gt_o),
   .eq_o      (eq_o),
   .lt_o      (lt_o)
);

// File: tb/sim_mcmp_ripple.sv
module sim_mcmp_ripple;

   localparam int WIDTH = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [WIDTH-1:0] a, b;
   logic             cg, ce, cl;
   logic             gt, eq, lt;

   int n_cmp  = 0;
   int n_bad  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   logic [2:0] exp_q [$];
   string      tag_q [$];

   always #4 clk = ~clk;

   mcmp_ripple #(.WIDTH(WIDTH)) u0 (
      .a_i (a), .b_i (b),
      .casc_gt_i (cg), .casc_eq_i (ce), .casc_lt_i (cl),
      .gt_o (gt), .eq_o (eq), .lt_o (lt)
   );

   function automatic logic [2:0] model(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                                        input logic g, input logic e, input logic l);
      if (x > y)  return 3'b100;
      if (x < y)  return 3'b001;
      if (e)      return 3'b010;
      return {g, 1'b0, l};
   endfunction

   task automatic drive(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                        input logic g, input logic e, input logic l, input string tag);
      @(posedge clk);
      a = x; b = y; cg = g; ce = e; cl = l;
      exp_q.push_back(model(x, y, g, e, l));
      tag_q.push_back(tag);
   endtask

   // monitor: compares at the falling edge, half a cycle after driving
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         logic [2:0] e3;
         string      t;
         e3 = exp_q.pop_front();
         t  = tag_q.pop_front();
         n_cmp++;
         if ({gt, eq, lt} !== e3) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h got gt/eq/lt=%b expected %b", t, a, b, {gt, eq, lt}, e3);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; cg = 1'b0; ce = 1'b1; cl = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: zero operands, stand-alone ties (R5)
      drive(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, "R5 reset");
      // R3: equal cascade overrides hostile gt/lt
      drive(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b1, "R3 all-ones");
      drive(16'h1234, 16'h1234, 1'b0, 1'b1, 1'b1, "R3");
      // R4: pass-through of cascade when equal input low
      drive(16'hA5A5, 16'hA5A5, 1'b1, 1'b0, 1'b0, "R4 gt");
      drive(16'hA5A5, 16'hA5A5, 1'b0, 1'b0, 1'b1, "R4 lt");
      drive(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, "R4 illegal both");
      drive(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, "R4 none");
      // R1: top bit decides over lower bits
      drive(16'h8000, 16'h7FFF, 1'b0, 1'b1, 1'b0, "R1 msb");
      drive(16'h0FFF, 16'h1000, 1'b0, 1'b1, 1'b0, "R1 slice3");
      // R6: LSB-only difference with hostile cascade
      drive(16'h1235, 16'h1234, 1'b0, 1'b0, 1'b1, "R6 lsb gt");
      drive(16'h1234, 16'h1235, 1'b1, 1'b1, 1'b0, "R6 lsb lt");
      drive(16'hFFFE, 16'hFFFF, 1'b1, 1'b0, 1'b1, "R6 lsb lt");
      // R7: middle slice decides against lower slices
      drive(16'h0F00, 16'h0EFF, 1'b0, 1'b1, 1'b0, "R7 mid slice");
      drive(16'h00E0, 16'h00F0, 1'b1, 1'b0, 1'b0, "R7 slice1");
      // R8: BCD operands
      drive(16'h0099, 16'h0100, 1'b0, 1'b1, 1'b0, "R8 bcd 99<100");
      drive(16'h2000, 16'h1999, 1'b0, 1'b1, 1'b0, "R8 bcd 2000>1999");
      drive(16'h0909, 16'h0909, 1'b0, 1'b1, 1'b0, "R8 bcd equal");
      // R2: random pairs and cascades
      for (int i = 0; i < 300; i++) begin
         logic [WIDTH-1:0] x, y;
         x = WIDTH'($urandom);
         y = (i % 4 == 0) ? x ^ WIDTH'(1 << (i % WIDTH)) : WIDTH'($urandom);
         if (i % 7 == 0) y = x;
         drive(x, y, 1'($urandom), 1'($urandom), 1'($urandom), "R2 random");
      end
      @(posedge clk);
      @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule